// File: doc/BRIEF.md
# Test Status and Shutdown Control Peripheral

A small memory-mapped slave used by a processor under test inside a simulation environment. The processor reports the outcome of a test by writing a result word, names the test by writing a pointer to a name string held in system memory, and asks for the run to end by writing to a control word. The block turns those writes into a one-cycle shutdown request, a one-cycle result event with a pass/fail flag, and a 16-byte captured copy of the test name.

Writing the name pointer starts an autonomous fetch. A byte-wide read-master port issues sixteen valid/ready read requests at consecutive byte addresses and collects one byte per response into the name buffer. The final byte is always forced to zero so the captured string is terminated. While the fetch runs, the register write port holds its ready low. As a result, a result write that follows a name write produces its event only after the name has been captured. Narrow writes inside the window are ignored. Writes outside the window change nothing and pulse an error output.

Top module: `tstat_ctrl`

## Requirements
- R1: The window starts at parameter BASE_ADDR (default 0xFFFF0000) and spans 12 bytes. Register index is (address - BASE_ADDR) >> 2: index 0 is control, index 1 is the result word, index 2 is the name pointer.
- R2: An accepted full-word write to the control register pulses shutdown_req high for exactly the cycle after acceptance, whatever the data value.
- R3: An accepted full-word write to the result register stores the data in pf_value and pulses result_valid for the cycle after acceptance, with result_fail = 1 when the data is non-zero and 0 when it is zero.
- R4: An accepted full-word write to the name-pointer register stores the pointer in name_ptr. It then issues 16 read requests at addresses pointer+0 through pointer+15 in that order. The k-th response byte is stored in name_buf[8k+7:8k].
- R5: When the fetch completes, byte 15 of name_buf (bits 127:120) is zero, whatever the memory returned.
- R6: fetch_busy is high from the cycle after the name-pointer write until the cycle after the 16th response. While it is high, wr_ready is low and no register write is taken.
- R7: Reset clears pf_value, name_ptr, every byte of name_buf, and all pulse and busy outputs, and leaves wr_ready high.
- R8: wr_size encodes 2'b10 as a 32-bit write. Writes with 2'b00 (byte) or 2'b01 (halfword) inside the window change no state and raise no pulse.
- R9: An accepted write of any size whose address lies outside the window pulses access_err for the cycle after acceptance and changes no register, buffer or other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | 32 | Byte address of the write |
| wr_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| wr_data | input | 32 | Write data |
| mem_req_valid | output | 1 | Name fetch read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read response byte present |
| mem_rsp_data | input | 8 | Read response byte |
| shutdown_req | output | 1 | One-cycle request to end the run |
| result_valid | output | 1 | One-cycle result event |
| result_fail | output | 1 | Fail flag of the result event |
| access_err | output | 1 | One-cycle bad-address indication |
| fetch_busy | output | 1 | Name fetch in progress |
| pf_value | output | 32 | Stored result word |
| name_ptr | output | 32 | Stored name pointer |
| name_buf | output | 128 | Captured name, byte k at bits 8k+7:8k |

## Verification
The decoder is driven with every register offset at full width. It is also driven with halfword and byte writes to live offsets, and with addresses just past the end and just below the base. This separates decode, size filtering and error signalling. Result words of zero, small, sign-bit-only and arbitrary values check that the fail flag follows any non-zero bit. The name fetch runs with a memory whose request-ready stalls periodically and whose data depends on the address. A pointer that carries across a byte boundary shows that the address increments and byte ordering are right. A memory byte that is non-zero at offset 15 shows that the terminator is forced. A result write queued behind a name write checks the stall.

// File: rtl/tstat_pkg.sv
package tstat_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned REG_COUNT = 3;
    localparam int unsigned WIN_BYTES = REG_COUNT * (WORD_W / 8);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } acc_size_e;

    // one-hot decode result of a register write address
    typedef struct packed {
        logic ctrl;
        logic result;
        logic nameptr;
        logic bad;
    } wr_hit_t;
endpackage

// File: rtl/tstat_decode.sv
module tstat_decode
    import tstat_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic [31:0] addr,
    output wr_hit_t     hit
);
    logic [31:0] offset;
    logic [31:0] index;
    logic        in_win;

    always_comb begin
        offset      = addr - BASE_ADDR;
        index       = offset >> 2;
        in_win      = offset < 32'(WIN_BYTES);
        hit.ctrl    = in_win && (index == 32'd0);
        hit.result  = in_win && (index == 32'd1);
        hit.nameptr = in_win && (index == 32'd2);
        hit.bad     = !in_win;
    end
endmodule

// File: rtl/tstat_name_fetch.sv
module tstat_name_fetch #(
    parameter int unsigned NAME_BYTES = 16,
    parameter int unsigned ADDR_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       start_ptr,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [ADDR_W-1:0]       req_addr,
    input  logic                    rsp_valid,
    input  logic [7:0]              rsp_data,
    output logic                    busy,
    output logic [ADDR_W-1:0]       ptr,
    output logic [NAME_BYTES*8-1:0] name_flat
);
    localparam int unsigned IDX_W = $clog2(NAME_BYTES);
    localparam int unsigned CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NAME_BYTES - 1);
    localparam logic [CNT_W-1:0] TOTAL = CNT_W'(NAME_BYTES);

    typedef struct packed {
        logic                        busy;
        logic [CNT_W-1:0]            req_cnt;
        logic [CNT_W-1:0]            rsp_cnt;
        logic [ADDR_W-1:0]           ptr;
        logic [NAME_BYTES-1:0][7:0]  buf_b;
    } fetch_st_t;

    fetch_st_t st_d, st_q;
    logic [IDX_W-1:0] wr_idx;

    always_comb begin
        st_d      = st_q;
        req_valid = st_q.busy && (st_q.req_cnt < TOTAL);
        req_addr  = st_q.ptr + ADDR_W'(st_q.req_cnt);
        wr_idx    = st_q.rsp_cnt[IDX_W-1:0];
        if (start && !st_q.busy) begin
            st_d.busy    = 1'b1;
            st_d.ptr     = start_ptr;
            st_d.req_cnt = '0;
            st_d.rsp_cnt = '0;
        end else if (st_q.busy) begin
            if (req_valid && req_ready) begin
                st_d.req_cnt = st_q.req_cnt + 1'b1;
            end
            if (rsp_valid) begin
                // the final byte is the string terminator
                st_d.buf_b[wr_idx] = (st_q.rsp_cnt == LAST) ? 8'h00 : rsp_data;
                st_d.rsp_cnt       = st_q.rsp_cnt + 1'b1;
                if (st_q.rsp_cnt == LAST) begin
                    st_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign ptr       = st_q.ptr;
    assign name_flat = st_q.buf_b;

    assert_rsp_not_ahead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.rsp_cnt <= st_q.req_cnt));
    assert_terminated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> (name_flat[NAME_BYTES*8-1 -: 8] == 8'h00));
    assert_req_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (st_q.req_cnt != TOTAL));
endmodule

// File: rtl/tstat_ctrl.sv
module tstat_ctrl
    import tstat_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'hFFFF_0000,
    parameter int unsigned NAME_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic [31:0]             wr_addr,
    input  logic [1:0]              wr_size,
    input  logic [31:0]             wr_data,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [31:0]             mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [7:0]              mem_rsp_data,
    output logic                    shutdown_req,
    output logic                    result_valid,
    output logic                    result_fail,
    output logic                    access_err,
    output logic                    fetch_busy,
    output logic [31:0]             pf_value,
    output logic [31:0]             name_ptr,
    output logic [NAME_BYTES*8-1:0] name_buf
);
    typedef struct packed {
        logic        shutdown;
        logic        res_valid;
        logic        res_fail;
        logic        err;
        logic [31:0] pf;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    wr_hit_t  hit;
    logic     accept;
    logic     is_word;
    logic     fetch_start;

    tstat_decode #(.BASE_ADDR(BASE_ADDR)) u_decode (
        .addr (wr_addr),
        .hit  (hit)
    );

    tstat_name_fetch #(.NAME_BYTES(NAME_BYTES), .ADDR_W(32)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fetch_start),
        .start_ptr (wr_data),
        .req_valid (mem_req_valid),
        .req_ready (mem_req_ready),
        .req_addr  (mem_req_addr),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .busy      (fetch_busy),
        .ptr       (name_ptr),
        .name_flat (name_buf)
    );

    assign wr_ready = !fetch_busy;

    always_comb begin
        accept      = wr_valid && wr_ready;
        is_word     = (wr_size == SZ_WORD);
        fetch_start = accept && is_word && hit.nameptr;
        st_d           = st_q;
        st_d.shutdown  = 1'b0;
        st_d.res_valid = 1'b0;
        st_d.err       = 1'b0;
        if (accept) begin
            if (hit.bad) begin
                st_d.err = 1'b1;
            end else if (is_word) begin
                if (hit.ctrl) begin
                    st_d.shutdown = 1'b1;
                end
                if (hit.result) begin
                    st_d.pf        = wr_data;
                    st_d.res_valid = 1'b1;
                    st_d.res_fail  = |wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shutdown_req = st_q.shutdown;
    assign result_valid = st_q.res_valid;
    assign result_fail  = st_q.res_fail;
    assign access_err   = st_q.err;
    assign pf_value     = st_q.pf;

    assert_result_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (result_fail == (pf_value != 32'd0)));
    assert_err_no_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |-> ($stable(pf_value) && $stable(name_ptr) && !shutdown_req && !result_valid));
    assert_hold_during_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_busy |=> ($stable(pf_value) && !shutdown_req && !result_valid && !access_err));
    assert_decode_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shutdown_req, result_valid, access_err}));
endmodule

// File: tb/tstat_ctrl_bench.sv
module tstat_ctrl_bench;
    localparam logic [31:0] BASE = 32'hFFFF_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic [31:0]  wr_addr = '0;
    logic [1:0]   wr_size = 2'b10;
    logic [31:0]  wr_data = '0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [7:0]   mem_rsp_data = '0;
    logic         shutdown_req, result_valid, result_fail, access_err, fetch_busy;
    logic [31:0]  pf_value, name_ptr;
    logic [127:0] name_buf;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    tstat_ctrl u_tstat_ctrl (.*);

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return (a[7:0] + 8'h31) ^ a[15:8];
    endfunction

    // memory model: periodic ready stall, one response per accepted request
    logic        fire_pend = 1'b0;
    logic [31:0] fire_addr = '0;
    logic [31:0] req_log [16];
    int          req_n = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_rsp_valid = 1'b0;
            fire_pend     = 1'b0;
        end else begin
            mem_rsp_valid = fire_pend;
            mem_rsp_data  = mem_byte(fire_addr);
            mem_req_ready = (cyc % 3) != 1;
            fire_pend     = mem_req_valid && mem_req_ready;
            if (fire_pend) begin
                fire_addr = mem_req_addr;
                if (req_n < 16) req_log[req_n] = mem_req_addr;
                req_n++;
            end
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_size = sz; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && fetch_busy; i++) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  pulses;   // shutdown, result, fail, err
        logic [31:0] pf;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'b10, BASE + 32'h0, 32'h0000_0000, 4'b1000, 32'h0},          // R2
        '{2'b10, BASE + 32'h0, 32'hDEAD_BEEF, 4'b1000, 32'h0},          // R2
        '{2'b10, BASE + 32'h4, 32'h0000_0000, 4'b0100, 32'h0},          // R3 pass
        '{2'b10, BASE + 32'h4, 32'h0000_0007, 4'b0110, 32'h7},          // R3 fail
        '{2'b01, BASE + 32'h4, 32'h0000_0000, 4'b0010, 32'h7},          // R8 half
        '{2'b00, BASE + 32'h0, 32'h0000_0001, 4'b0010, 32'h7},          // R8 byte
        '{2'b10, BASE + 32'hC, 32'h0000_0000, 4'b0011, 32'h7},          // R9 past end
        '{2'b10, BASE - 32'h4, 32'h0000_0000, 4'b0011, 32'h7},          // R9 below base
        '{2'b10, BASE + 32'h4, 32'h8000_0000, 4'b0110, 32'h8000_0000},  // R3 sign bit
        '{2'b10, BASE + 32'h4, 32'h0000_0000, 4'b0100, 32'h0}           // R3 pass
    };

    task automatic run_fetch(input logic [31:0] p, input string tag);
        req_n = 0;
        do_write(BASE + 32'h8, 2'b10, p);
        chk({tag, " R6 busy after write"}, 128'(fetch_busy), 128'(1));
        chk({tag, " R6 ready low"}, 128'(wr_ready), 128'(0));
        chk({tag, " R4 pointer stored"}, 128'(name_ptr), 128'(p));
        wait_idle();
        chk({tag, " R4 request count"}, 128'(req_n), 128'(16));
        for (int k = 0; k < 16; k++) begin
            chk({tag, " R4 request addr"}, 128'(req_log[k]), 128'(p + 32'(k)));
        end
        for (int k = 0; k < 15; k++) begin
            chk({tag, " R4 name byte"}, 128'(name_buf[8*k +: 8]), 128'(mem_byte(p + 32'(k))));
        end
        chk({tag, " R5 terminator"}, 128'(name_buf[127:120]), 128'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        chk("R7 pf_value", 128'(pf_value), 128'(0));
        chk("R7 name_ptr", 128'(name_ptr), 128'(0));
        chk("R7 name_buf", name_buf, 128'(0));
        chk("R7 pulses", 128'({shutdown_req, result_valid, access_err, fetch_busy}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 wr_ready", 128'(wr_ready), 128'(1));

        for (int v = 0; v < NV; v++) begin
            do_write(VECS[v].addr, VECS[v].sz, VECS[v].data);
            chk($sformatf("R1 vec%0d shutdown R2", v), 128'(shutdown_req), 128'(VECS[v].pulses[3]));
            chk($sformatf("R1 vec%0d result R3", v), 128'(result_valid), 128'(VECS[v].pulses[2]));
            if (VECS[v].pulses[2])
                chk($sformatf("R3 vec%0d fail flag", v), 128'(result_fail), 128'(VECS[v].pulses[1]));
            chk($sformatf("R9 vec%0d access_err", v), 128'(access_err), 128'(VECS[v].pulses[0]));
            chk($sformatf("R8 vec%0d pf_value", v), 128'(pf_value), 128'(VECS[v].pf));
            chk($sformatf("R9 vec%0d name_ptr", v), 128'(name_ptr), 128'(0));
            @(negedge clk);
            chk($sformatf("R2 vec%0d pulses one cycle", v),
                128'({shutdown_req, result_valid, access_err}), 128'(0));
        end

        // name fetch across a byte carry; byte 15 of memory is non-zero
        run_fetch(32'h0000_20F8, "fetchA");
        // R8 narrow write to name pointer starts nothing
        do_write(BASE + 32'h8, 2'b00, 32'h1111_1111);
        chk("R8 narrow nameptr no fetch", 128'(fetch_busy), 128'(0));
        chk("R8 narrow nameptr ptr kept", 128'(name_ptr), 128'(32'h0000_20F8));

        // R6 result write queued behind a fetch: event only after the fetch
        req_n = 0;
        do_write(BASE + 32'h8, 2'b10, 32'h1234_5670);
        do_write(BASE + 32'h4, 2'b10, 32'h0000_0005);
        chk("R6 result after fetch", 128'(result_valid), 128'(1));
        chk("R6 fetch done at result", 128'(fetch_busy), 128'(0));
        chk("R6 all bytes in first", 128'(req_n), 128'(16));
        chk("R5 terminator B", 128'(name_buf[127:120]), 128'(0));
        chk("R4 byte0 B", 128'(name_buf[7:0]), 128'(mem_byte(32'h1234_5670)));
        chk("R3 stored 5", 128'(pf_value), 128'(5));

        // R9 bad write after fetch keeps pointer and buffer
        begin
            logic [127:0] snap;
            snap = name_buf;
            do_write(BASE + 32'h10, 2'b10, 32'hFFFF_FFFF);
            chk("R9 err pulse", 128'(access_err), 128'(1));
            chk("R9 buffer kept", name_buf, snap);
            chk("R9 pointer kept", 128'(name_ptr), 128'(32'h1234_5670));
        end

        // R7 reset after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 pf cleared", 128'(pf_value), 128'(0));
        chk("R7 ptr cleared", 128'(name_ptr), 128'(0));
        chk("R7 buf cleared", name_buf, 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R6 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule